// File: doc/BRIEF.md
# Strap-configured clock output controller

This block takes a fast core clock and a reference clock and produces ten clock outputs. Each output runs at one of a set of binary fractions of the core clock. Every output pin also acts as a configuration strap. For a fixed number of core-clock cycles after reset the pins are only read, and each pin's level sets the starting rate of its own output. When that window closes the pins start to drive clocks. After that, a simple parallel write port can change the rate and the enable of each output.

All outputs come from one shared phase counter, so their rising edges line up. A new rate or enable setting is applied only when the counter wraps. At that point every divided clock is low. A global output-enable input releases all pads to high impedance and leaves the clocks running inside the block. Two static test pins route the reference clock onto output 0 or onto every output.

The block has no streaming data path. Every pin is a plain control or clock signal with no valid/ready handshake and no back-pressure. Pads are modelled as separate input, output and output-enable vectors. The pad cells themselves are outside the block.

Top module: `clkout_ctrl`

## Requirements
- R1: From reset until WIN_CYCLES core-clock cycles after reset release, `pad_oe` is all zeros. Once the window has closed, `pad_oe` equals `oe` replicated on every bit.
- R2: The pad level seen during the window sets each output's starting rate. A level of 1 selects full rate, which has a period of 2 core cycles. A level of 0 selects half rate, which has a period of 4 core cycles. For output 9, a 0 selects rate code 1.
- R3: Writes made while the window is open are ignored. After the window closes, the outputs run at the rates given by the straps, and every output is enabled.
- R4: A write to address 0 sets the rate of outputs 0 to 8. In each bit, 1 selects full rate and 0 selects half rate. Bit 9 of the same write sets output 9 to code 0 when it is 1 and to code 1 when it is 0.
- R5: A write to address 2 sets output 9's rate code from `wr_data[1:0]`. Code 0 gives a period of 2 core cycles, code 1 gives 4, code 2 gives 8 and code 3 gives 16. Every code has a 50% duty cycle.
- R6: At address 1, bit i of the data is the enable for output i, where 1 means running. All enable bits come out of reset as 1. A disabled output stays low.
- R7: Every rising edge of every output falls on a rising edge of any enabled full-rate output.
- R8: Rate and enable changes take effect only when the shared phase counter wraps. After a change, no high or low pulse is shorter than the smaller of the half-periods before and after the change, and a running clock's high pulse is never cut short by a disable.
- R9: While `oe` is low, `pad_oe` is all zeros and the clocks on `pad_o` keep toggling.
- R10: With `ref_sel` high, `pad_o[0]` follows `ref_clk`, and the other outputs are unchanged.
- R11: With `test_mode` high, every bit of `pad_o` follows `ref_clk`. This takes priority over `ref_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast core clock, from the PLL |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk | input | 1 | Reference clock, used for the bypass and test routes |
| oe | input | 1 | Global pad drive enable |
| test_mode | input | 1 | Routes ref_clk onto all outputs |
| ref_sel | input | 1 | Routes ref_clk onto output 0 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 = rate bits, 1 = enable bits, 2 = output 9 rate code |
| wr_data | input | 10 | Write data |
| pad_i | input | 10 | Pad levels, sampled as straps during the window |
| pad_o | output | 10 | Clock outputs to the pads |
| pad_oe | output | 10 | Pad drive enables |

## Verification
The bench drives a strap pattern and also writes during the strap window. A design that captured the straps at the wrong time, or that let those early writes through, would come out of the window at the wrong rates. It then walks a set of rate and enable mixes, counting edges and high time on every output and checking that each edge lines up with a full-rate reference output. A shared counter that had been mis-sliced would show up there as wrong periods or offset edges. It also watches pulse widths across a switch from divide-by-8 to divide-by-4, and across a disable, where applying the change without waiting for the counter to wrap would leave runt pulses. The last checks cover the tri-state drop and both reference-clock routes, including the priority of the full test route over the output 0 route.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  localparam int DIV_W = 2;           // width of a rate code
  localparam int PH_W  = 1 << DIV_W;  // phase counter bits, covers slowest rate

  typedef enum logic [DIV_W-1:0] {
    RATE_FULL = 2'd0,
    RATE_HALF = 2'd1,
    RATE_QTR  = 2'd2,
    RATE_EIGH = 2'd3
  } rate_code_e;

  typedef enum logic [1:0] {
    ADDR_RATE = 2'd0,
    ADDR_ENAB = 2'd1,
    ADDR_XRAT = 2'd2
  } cfg_addr_e;
endpackage

// File: rtl/clkout_strap_timer.sv
module clkout_strap_timer #(
  parameter int WIN_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_open
);
  localparam int CW = $clog2(WIN_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == CW'(WIN_CYCLES - 1)) done_q <= 1'b1;
      else                              cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign win_open = !done_q;

  // R1: once closed the window never reopens
  a_r1_window_once: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> !win_open);
endmodule

// File: rtl/clkout_cfg.sv
module clkout_cfg
  import clkout_pkg::*;
#(
  parameter int N_OUT = 10
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            win_open,
  input  logic [N_OUT-1:0]                pad_i,
  input  logic                            wr_en,
  input  logic [1:0]                      wr_addr,
  input  logic [N_OUT-1:0]                wr_data,
  output logic [N_OUT-1:0][DIV_W-1:0]     code,
  output logic [N_OUT-1:0]                en
);
  localparam int XI = N_OUT - 1;  // output with the extended divider

  logic [XI-1:0]    fast_q;
  logic [DIV_W-1:0] xcode_q;
  logic [N_OUT-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fast_q  <= '1;
      xcode_q <= RATE_FULL;
      en_q    <= '1;
    end else if (win_open) begin
      fast_q  <= pad_i[XI-1:0];
      xcode_q <= pad_i[XI] ? RATE_FULL : RATE_HALF;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_RATE: begin
          fast_q  <= wr_data[XI-1:0];
          xcode_q <= wr_data[XI] ? RATE_FULL : RATE_HALF;
        end
        ADDR_ENAB: en_q    <= wr_data;
        ADDR_XRAT: xcode_q <= wr_data[DIV_W-1:0];
        default:   ;
      endcase
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < XI; gi++) begin : g_code
      assign code[gi] = fast_q[gi] ? RATE_FULL : RATE_HALF;
    end
  endgenerate
  assign code[XI] = xcode_q;
  assign en       = en_q;

  // R4: settings stay put when no write arrives after the window
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_open && !wr_en) |=> ($stable(fast_q) && $stable(xcode_q) && $stable(en_q)));
endmodule

// File: rtl/clkout_divider.sv
module clkout_divider
  import clkout_pkg::*;
#(
  parameter int N_OUT = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_OUT-1:0][DIV_W-1:0] code,
  input  logic [N_OUT-1:0]            en,
  output logic [N_OUT-1:0]            clk_q
);
  logic [PH_W-1:0]             ph_q;
  logic [N_OUT-1:0]            act_en_q;
  logic [N_OUT-1:0][DIV_W-1:0] act_code_q;
  logic                        wrap;

  assign wrap = &ph_q;  // every divided clock is low in this phase

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q       <= '0;
      act_en_q   <= '0;
      act_code_q <= '0;
    end else begin
      ph_q <= ph_q + 1'b1;
      if (wrap) begin
        act_en_q   <= en;
        act_code_q <= code;
      end
    end
  end

  // R8: settings only move at the common wrap point
  a_r8_switch_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(act_en_q) && $stable(act_code_q)));

  genvar gi;
  generate
    for (gi = 0; gi < N_OUT; gi++) begin : g_out
      always_ff @(posedge clk) begin
        if (!rst_n) clk_q[gi] <= 1'b0;
        else        clk_q[gi] <= act_en_q[gi] & ~ph_q[act_code_q[gi]];
      end

      // R6: a disabled output stays low
      a_r6_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !act_en_q[gi] |=> !clk_q[gi]);

      // R7: rising edges only leave an even phase
      a_r7_rise_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_q[gi]) |-> ph_q[0]);
    end
  endgenerate
endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
  import clkout_pkg::*;
#(
  parameter int N_OUT      = 10,
  parameter int WIN_CYCLES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_clk,
  input  logic             oe,
  input  logic             test_mode,
  input  logic             ref_sel,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [N_OUT-1:0] wr_data,
  input  logic [N_OUT-1:0] pad_i,
  output logic [N_OUT-1:0] pad_o,
  output logic [N_OUT-1:0] pad_oe
);
  logic                        win_open;
  logic [N_OUT-1:0][DIV_W-1:0] code;
  logic [N_OUT-1:0]            en;
  logic [N_OUT-1:0]            div_clk;

  clkout_strap_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_open (win_open)
  );

  clkout_cfg #(.N_OUT(N_OUT)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_open (win_open),
    .pad_i    (pad_i),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .code     (code),
    .en       (en)
  );

  clkout_divider #(.N_OUT(N_OUT)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .code  (code),
    .en    (en),
    .clk_q (div_clk)
  );

  genvar gi;
  generate
    for (gi = 0; gi < N_OUT; gi++) begin : g_pad
      if (gi == 0) begin : g_bypass
        assign pad_o[gi] = (test_mode || ref_sel) ? ref_clk : div_clk[gi];
      end else begin : g_plain
        assign pad_o[gi] = test_mode ? ref_clk : div_clk[gi];
      end
    end
  endgenerate

  assign pad_oe = {N_OUT{oe & ~win_open}};
endmodule

// File: tb/clkout_ctrl_bench.sv
module clkout_ctrl_bench;
  localparam int N   = 10;
  localparam int WIN = 32;
  localparam int MW  = 32;  // measurement window in core cycles

  // {rate[9:0], enable[9:0], out9 code[1:0]}; bit 0 always fast and enabled
  localparam logic [21:0] VEC [4] = '{
    {10'h3FF, 10'h3FF, 2'd0},
    {10'h0F1, 10'h3FF, 2'd1},
    {10'h30F, 10'h2D5, 2'd2},
    {10'h001, 10'h3C3, 2'd3}
  };

  logic clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic oe = 1'b1, test_mode = 1'b0, ref_sel = 1'b0, wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [N-1:0] wr_data = '0, pad_i = '0, pad_o, pad_oe;

  int n_chk = 0, n_fail = 0;
  int m_rise [N];
  int m_high [N];
  int m_mis;

  always #2.5 clk = ~clk;
  always #7   ref_clk = ~ref_clk;

  clkout_ctrl #(.N_OUT(N), .WIN_CYCLES(WIN)) u_clkout_ctrl (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .oe(oe), .test_mode(test_mode),
    .ref_sel(ref_sel), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // counts rises and high samples; misalign = rises without a rise on output 0
  task automatic measure();
    logic [N-1:0] prev;
    @(negedge clk); prev = pad_o; m_mis = 0;
    for (int i = 0; i < N; i++) begin m_rise[i] = 0; m_high[i] = 0; end
    repeat (MW) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        if (pad_o[i]) m_high[i]++;
        if (pad_o[i] && !prev[i]) begin
          m_rise[i]++;
          if (!(pad_o[0] && !prev[0])) m_mis++;
        end
      end
      prev = pad_o;
    end
  endtask

  task automatic runs(input int idx, input int cycles, input int min_hi,
                      input int min_lo, output int shorts);
    logic prev; int run; bit started;
    @(negedge clk); prev = pad_o[idx]; run = 0; started = 0; shorts = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (pad_o[idx] == prev) run++;
      else begin
        if (started && prev && run < min_hi) shorts++;
        if (started && !prev && run < min_lo) shorts++;
        started = 1; run = 1; prev = pad_o[idx];
      end
    end
  endtask

  function automatic int exp_rise(input int code);
    return 16 >> code;
  endfunction

  initial begin
    #1_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int sh, ok;
    logic [N-1:0] strap;
    strap = 10'h1B5;  // bit0=1 fast, bit9=0 -> out9 half
    pad_i = strap;
    repeat (4) @(negedge clk);
    chk("R1 reset pad_oe", int'(pad_oe), 0);
    chk("R1 reset pad_o", int'(pad_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 window pad_oe", int'(pad_oe), 0);
    wr(2'd0, 10'h000);  // R3: ignored inside the window
    wr(2'd1, 10'h000);
    repeat (WIN - 3) @(negedge clk);
    chk("R1 drive after window", int'(pad_oe), 10'h3FF);
    pad_i = ~strap;  // late pad changes must not matter
    repeat (40) @(negedge clk);
    measure();
    for (int i = 0; i < N; i++) begin
      chk($sformatf("R2 R3 strap rate out%0d", i), m_rise[i], strap[i] ? 16 : 8);
      chk($sformatf("R6 reset enable out%0d", i), m_high[i], 16);
    end

    // table walk: R4 R5 R6 R7
    for (int v = 0; v < 4; v++) begin
      wr(2'd0, VEC[v][21:12]);
      wr(2'd1, VEC[v][11:2]);
      wr(2'd2, {8'd0, VEC[v][1:0]});
      repeat (40) @(negedge clk);
      measure();
      for (int i = 0; i < N - 1; i++) begin
        chk($sformatf("R4 v%0d rate out%0d", v, i), m_rise[i],
            VEC[v][2 + i] ? (VEC[v][12 + i] ? 16 : 8) : 0);
        chk($sformatf("R6 v%0d enable out%0d", v, i), m_high[i], VEC[v][2 + i] ? 16 : 0);
      end
      chk($sformatf("R5 v%0d out9 rate", v), m_rise[9],
          VEC[v][11] ? exp_rise(int'(VEC[v][1:0])) : 0);
      chk($sformatf("R5 v%0d out9 duty", v), m_high[9], VEC[v][11] ? 16 : 0);
      chk($sformatf("R7 v%0d alignment", v), m_mis, 0);
    end

    // R8: /8 -> /4 on output 9
    wr(2'd1, 10'h3FF);
    wr(2'd2, 10'd3);
    repeat (40) @(negedge clk);
    wr(2'd2, 10'd2);
    runs(9, 80, 4, 4, sh);
    chk("R8 no runt on rate switch", sh, 0);
    measure();
    chk("R8 R5 new rate after switch", m_rise[9], 4);
    // R8: disable from /8 keeps full high pulses
    wr(2'd2, 10'd3);
    repeat (40) @(negedge clk);
    wr(2'd1, 10'h1FF);
    runs(9, 60, 8, 1, sh);
    chk("R8 no truncated high on disable", sh, 0);
    measure();
    chk("R8 R6 disabled stays low", m_high[9], 0);

    // R9: tri-state with clocks running
    wr(2'd0, 10'h3FF);
    wr(2'd1, 10'h3FF);
    repeat (40) @(negedge clk);
    oe = 1'b0;
    @(negedge clk);
    chk("R9 oe low pad_oe", int'(pad_oe), 0);
    measure();
    chk("R9 clocks keep running", m_rise[3], 16);
    oe = 1'b1;
    @(negedge clk);
    chk("R9 oe high pad_oe", int'(pad_oe), 10'h3FF);

    // R10: output 0 bypass
    ref_sel = 1'b1;
    ok = 1;
    repeat (24) begin
      @(negedge clk);
      if (pad_o[0] != ref_clk) ok = 0;
    end
    chk("R10 out0 follows ref_clk", ok, 1);
    measure();
    chk("R10 other outputs unchanged", m_rise[1], 16);

    // R11: full test route, priority over ref_sel
    test_mode = 1'b1;
    ok = 1;
    repeat (24) begin
      @(negedge clk);
      if (pad_o != {N{ref_clk}}) ok = 0;
    end
    chk("R11 all outputs follow ref_clk", ok, 1);
    ref_sel = 1'b0;
    ok = 1;
    repeat (24) begin
      @(negedge clk);
      if (pad_o != {N{ref_clk}}) ok = 0;
    end
    chk("R11 test route without ref_sel", ok, 1);
    test_mode = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule